// File: doc/BRIEF.md
# Frequency-Scaled Precision Time Counter

This block keeps a 64-bit time value whose rate is set by software. A 32-bit accumulator adds a programmable addend to itself on every clock. Each time that sum overflows, the time value goes up by one. The addend is therefore the fraction of a tick gained per clock, and a servo in software can trim the rate by rewriting it.

A 64-bit target value is compared, unsigned, against the running time. When time reaches the target, a sticky event flag is raised. That flag drives an interrupt if the interrupt is enabled.

The host reaches the block through a plain word-wide register port, with one strobe for writes and one for reads. Read data arrives one clock after the read strobe. The port carries no stream traffic, so it has no valid/ready handshake and applies no back-pressure. A host may issue one access per clock.

Both 64-bit values are accessed low word first. The low-word read and the low-word write each stage the other half of the value, so that software always sees and loads a coherent 64-bit quantity.

Top module: `ptime_counter`

## Requirements
- R1: After reset, the following hold:
  - time reads 0, the addend reads 0, control reads 0 and the event register reads 0;
  - both target words read 0xFFFFFFFF;
  - `irq` is 0.
- R2: The accumulator starts from 0 and holds addend A for N clocks. Over that span, time advances by floor(N*A/2^32), one step per accumulator carry. The addend is at offset 2.
- R3: While the addend is 0, time keeps its value.
- R4: A write to the addend leaves the accumulator value unchanged. A partial sum left by one addend therefore carries into the next.
- R5: A read of offset 0 returns time bits 31:0 and copies time bits 63:32 into a shadow. A read of offset 1 returns that shadow, even if time has carried into the high word since the low-word read.
- R6: A write to offset 0 only stages the low word, and time is unchanged. The next write to offset 1 loads {written word, staged word} into time. Any carry in that same clock is lost.
- R7: A write to target offset 3 only stages the low word, and the target is unchanged. A write to offset 4 loads {written word, staged word} as the new target. Offsets 3 and 4 read back the current target words.
- R8: Bit 0 of the event register (offset 6) becomes 1 one clock after time is greater than or equal to the target. The comparison is unsigned over all 64 bits.
- R9: The event bit stays 1 until a write to offset 6 with data bit 0 set. A write with bit 0 clear has no effect. If the compare still holds when the bit is cleared, the bit is set again.
- R10: `irq` is 1 exactly when the event bit and control bit 0 (offset 5) are both 1.
- R11: `reg_rdata` is updated on the clock that samples `reg_rd`. The addend and control read back their written values. Offset 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one word per clock |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 3 | Word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Target-reached interrupt |

## Verification
The bench builds the block with its default widths: a 32-bit word, a 64-bit time and a 32-bit accumulator.

It chooses addends that are exact binary fractions, such as one quarter and three eighths. With these, the tick count over a counted number of clocks has no remainder and can be predicted exactly.

It also preloads time and target just below a word boundary. This brings two cases within reach in a few clocks: a carry from the low word into the high word between the two halves of a read, and high-word ordering in the compare.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_TIME_LO = 3'd0,
    A_TIME_HI = 3'd1,
    A_ADDEND  = 3'd2,
    A_TGT_LO  = 3'd3,
    A_TGT_HI  = 3'd4,
    A_CTRL    = 3'd5,
    A_EVENT   = 3'd6
  } reg_off_e;
endpackage

// File: rtl/ptc_rate_gen.sv
module ptc_rate_gen #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addend_wr,
  input  logic [ACC_W-1:0] addend_wdata,
  output logic [ACC_W-1:0] addend_q,
  output logic             tick
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;

  // The carry out of the wide sum is the tick; the sum bits wrap into the accumulator.
  always_comb {tick, acc_sum} = {1'b0, acc_q} + {1'b0, addend_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      addend_q <= '0;
    end else begin
      acc_q <= acc_sum;
      if (addend_wr) addend_q <= addend_wdata;
    end
  end
endmodule

// File: rtl/ptc_time_ctr.sv
module ptc_time_ctr #(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  output logic [TIME_W-1:0] time_q
);
  // A load takes priority, so a tick in the load clock is lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    time_q <= '0;
    else if (load) time_q <= load_val;
    else if (tick) time_q <= time_q + TIME_W'(1);
  end
endmodule

// File: rtl/ptc_target_cmp.sv
module ptc_target_cmp #(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  input  logic              clear,
  input  logic [TIME_W-1:0] time_q,
  output logic [TIME_W-1:0] target_q,
  output logic              evt_q
);
  logic hit;

  // Unsigned magnitude compare.
  always_comb hit = (time_q >= target_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '1;
      evt_q    <= 1'b0;
    end else begin
      if (load) target_q <= load_val;
      evt_q <= hit | (evt_q & ~clear);
    end
  end
endmodule

// File: rtl/ptime_counter.sv
module ptime_counter #(
  parameter int unsigned REG_W = 32,
  parameter int unsigned ACC_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [ptc_pkg::ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]           reg_wdata,
  output logic [REG_W-1:0]           reg_rdata,
  output logic                       irq
);
  import ptc_pkg::*;

  localparam int unsigned TIME_W = 2 * REG_W;

  logic              wr_tlo, wr_thi, wr_add, wr_glo, wr_ghi, wr_ctl, wr_evt;
  logic [REG_W-1:0]  pend_tlo_q, pend_glo_q, shadow_hi_q;
  logic              irq_en_q;
  logic              tick, time_load, tgt_load, evt_clr, evt_q;
  logic [TIME_W-1:0] time_q, target_q, time_ld_val, tgt_ld_val;
  logic [ACC_W-1:0]  addend_q;
  logic [REG_W-1:0]  rd_mux;

  always_comb begin
    wr_tlo = reg_wr && (reg_addr == A_TIME_LO);
    wr_thi = reg_wr && (reg_addr == A_TIME_HI);
    wr_add = reg_wr && (reg_addr == A_ADDEND);
    wr_glo = reg_wr && (reg_addr == A_TGT_LO);
    wr_ghi = reg_wr && (reg_addr == A_TGT_HI);
    wr_ctl = reg_wr && (reg_addr == A_CTRL);
    wr_evt = reg_wr && (reg_addr == A_EVENT);
    time_load   = wr_thi;
    time_ld_val = {reg_wdata, pend_tlo_q};
    tgt_load    = wr_ghi;
    tgt_ld_val  = {reg_wdata, pend_glo_q};
    evt_clr     = wr_evt & reg_wdata[0];
    irq         = evt_q & irq_en_q;
  end

  ptc_rate_gen #(.ACC_W(ACC_W)) u_rate (
    .clk(clk), .rst_n(rst_n),
    .addend_wr(wr_add), .addend_wdata(reg_wdata[ACC_W-1:0]),
    .addend_q(addend_q), .tick(tick)
  );

  ptc_time_ctr #(.TIME_W(TIME_W)) u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .load(time_load), .load_val(time_ld_val), .time_q(time_q)
  );

  ptc_target_cmp #(.TIME_W(TIME_W)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .load(tgt_load), .load_val(tgt_ld_val), .clear(evt_clr),
    .time_q(time_q), .target_q(target_q), .evt_q(evt_q)
  );

  always_comb begin
    case (reg_addr)
      A_TIME_LO: rd_mux = time_q[REG_W-1:0];
      A_TIME_HI: rd_mux = shadow_hi_q;
      A_ADDEND:  rd_mux = REG_W'(addend_q);
      A_TGT_LO:  rd_mux = target_q[REG_W-1:0];
      A_TGT_HI:  rd_mux = target_q[TIME_W-1:REG_W];
      A_CTRL:    rd_mux = REG_W'(irq_en_q);
      A_EVENT:   rd_mux = REG_W'(evt_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_tlo_q  <= '0;
      pend_glo_q  <= '0;
      shadow_hi_q <= '0;
      irq_en_q    <= 1'b0;
      reg_rdata   <= '0;
    end else begin
      if (wr_tlo) pend_tlo_q <= reg_wdata;
      if (wr_glo) pend_glo_q <= reg_wdata;
      if (wr_ctl) irq_en_q   <= reg_wdata[0];
      if (reg_rd) begin
        reg_rdata <= rd_mux;
        if (reg_addr == A_TIME_LO) shadow_hi_q <= time_q[TIME_W-1:REG_W];
      end
    end
  end
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned ACC_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TIME_W-1:0] time_q,
  input logic [TIME_W-1:0] target_q,
  input logic [TIME_W-1:0] time_ld_val,
  input logic [ACC_W-1:0]  addend_q,
  input logic              time_load,
  input logic              evt_q,
  input logic              evt_clr,
  input logic              irq_en_q,
  input logic              irq
);
  // R2: without a load, time moves by at most one per clock
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !time_load |=> (time_q == $past(time_q) || time_q == $past(time_q) + TIME_W'(1)));

  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addend_q == '0 && !time_load) |=> (time_q == $past(time_q)));

  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    time_load |=> (time_q == $past(time_ld_val)));

  p_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (time_q >= target_q) |=> evt_q);

  p_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q && !evt_clr) |=> evt_q);

  p_irq_evt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> evt_q);

  p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_q |-> !irq);
endmodule

bind ptime_counter ptc_checker #(.TIME_W(TIME_W), .ACC_W(ACC_W)) u_ptc_checker (
  .clk(clk), .rst_n(rst_n), .time_q(time_q), .target_q(target_q),
  .time_ld_val(time_ld_val), .addend_q(addend_q), .time_load(time_load),
  .evt_q(evt_q), .evt_clr(evt_clr), .irq_en_q(irq_en_q), .irq(irq)
);

// File: tb/test_ptime_counter.sv
`timescale 1ns/1ps
module test_ptime_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] d;
  logic [63:0] v;

  always #2.5 clk = ~clk;

  ptime_counter i_ptime_counter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic do_reset();
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] dat);
    reg_addr = a; reg_wdata = dat; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] dat);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    dat = reg_rdata;
  endtask

  task automatic rd64(input logic [2:0] lo_a, output logic [63:0] val);
    logic [31:0] lo, hi;
    rd(lo_a, lo);
    rd(lo_a + 3'd1, hi);
    val = {hi, lo};
  endtask

  task automatic set_time(input logic [63:0] t);
    wr(3'd0, t[31:0]);
    wr(3'd1, t[63:32]);
  endtask

  task automatic set_tgt(input logic [63:0] t);
    wr(3'd3, t[31:0]);
    wr(3'd4, t[63:32]);
  endtask

  // Addend A is active for m+1 clocks.
  task automatic pulse(input logic [31:0] a, input int m);
    wr(3'd2, a);
    repeat (m) @(negedge clk);
    wr(3'd2, 32'd0);
  endtask

  task automatic t_reset();
    do_reset();
    rd64(3'd0, v); chk("R1 time", v, 64'd0);
    rd(3'd2, d);   chk("R1 addend", {32'd0, d}, 64'd0);
    rd(3'd5, d);   chk("R1 ctrl", {32'd0, d}, 64'd0);
    rd(3'd6, d);   chk("R1 event", {32'd0, d}, 64'd0);
    rd64(3'd3, v); chk("R1 target", v, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R1 irq", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_rate();
    do_reset();
    pulse(32'h4000_0000, 39);
    rd64(3'd0, v); chk("R2 quarter rate 40 clocks", v, 64'd10);
    pulse(32'h6000_0000, 15);
    rd64(3'd0, v); chk("R2 three-eighths rate 16 clocks", v, 64'd16);
  endtask

  task automatic t_stop();
    do_reset();
    set_time(64'd1234);
    repeat (20) @(negedge clk);
    rd64(3'd0, v); chk("R3 zero addend holds time", v, 64'd1234);
  endtask

  task automatic t_keep();
    do_reset();
    pulse(32'h8000_0000, 0);
    rd64(3'd0, v); chk("R4 half sum no tick", v, 64'd0);
    pulse(32'h8000_0000, 0);
    rd64(3'd0, v); chk("R4 residue carries", v, 64'd1);
  endtask

  task automatic t_coherent();
    do_reset();
    set_time(64'h0000_0000_FFFF_FFFF);
    rd(3'd0, d); chk("R5 low word", {32'd0, d}, 64'hFFFF_FFFF);
    pulse(32'h8000_0000, 1);
    rd(3'd1, d); chk("R5 high from shadow", {32'd0, d}, 64'd0);
    rd64(3'd0, v); chk("R5 fresh pair", v, 64'h0000_0001_0000_0000);
  endtask

  task automatic t_load();
    do_reset();
    wr(3'd0, 32'd100);
    rd(3'd0, d); chk("R6 low write staged only", {32'd0, d}, 64'd0);
    wr(3'd2, 32'hFFFF_FFFF);
    @(negedge clk);
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd0);
    rd64(3'd0, v); chk("R6 load drops carry", v, 64'd101);
  endtask

  task automatic t_tgt_stage();
    do_reset();
    set_time(64'd5);
    wr(3'd3, 32'd0);
    rd(3'd6, d); chk("R7 staged low no event", {32'd0, d}, 64'd0);
    rd(3'd3, d); chk("R7 target unchanged", {32'd0, d}, 64'hFFFF_FFFF);
    wr(3'd4, 32'd0);
    rd(3'd6, d); chk("R7 committed target", {32'd0, d}, 64'd1);
  endtask

  task automatic t_compare();
    do_reset();
    set_tgt(64'd7);
    set_time(64'd5);
    rd(3'd6, d); chk("R8 below", {32'd0, d}, 64'd0);
    set_time(64'd7);
    rd(3'd6, d); chk("R8 equal", {32'd0, d}, 64'd1);
    do_reset();
    set_tgt(64'h8000_0000_0000_0000);
    set_time(64'd5);
    rd(3'd6, d); chk("R8 unsigned", {32'd0, d}, 64'd0);
    set_tgt(64'h0000_0001_0000_0000);
    set_time(64'h0000_0000_FFFF_FFFF);
    rd(3'd6, d); chk("R8 high word order", {32'd0, d}, 64'd0);
    set_time(64'h0000_0001_0000_0000);
    rd(3'd6, d); chk("R8 high word equal", {32'd0, d}, 64'd1);
  endtask

  task automatic t_latch();
    do_reset();
    set_tgt(64'd7);
    set_time(64'd7);
    set_time(64'd3);
    rd(3'd6, d); chk("R9 stays latched", {32'd0, d}, 64'd1);
    wr(3'd6, 32'd0);
    rd(3'd6, d); chk("R9 zero write ignored", {32'd0, d}, 64'd1);
    wr(3'd6, 32'd1);
    rd(3'd6, d); chk("R9 cleared", {32'd0, d}, 64'd0);
    set_time(64'd9);
    wr(3'd6, 32'd1);
    rd(3'd6, d); chk("R9 re-set while true", {32'd0, d}, 64'd1);
  endtask

  task automatic t_irq();
    do_reset();
    set_tgt(64'd7);
    set_time(64'd7);
    repeat (2) @(negedge clk);
    chk("R10 masked", {63'd0, irq}, 64'd0);
    wr(3'd5, 32'd1);
    chk("R10 enabled", {63'd0, irq}, 64'd1);
    set_time(64'd3);
    wr(3'd6, 32'd1);
    @(negedge clk);
    chk("R10 cleared", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_read();
    do_reset();
    wr(3'd2, 32'h0000_1234);
    wr(3'd5, 32'd1);
    rd(3'd2, d); chk("R11 addend readback", {32'd0, d}, 64'h1234);
    rd(3'd5, d); chk("R11 ctrl readback", {32'd0, d}, 64'd1);
    rd(3'd7, d); chk("R11 unmapped", {32'd0, d}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_rate();
    t_stop();
    t_keep();
    t_coherent();
    t_load();
    t_tgt_stage();
    t_compare();
    t_latch();
    t_irq();
    t_read();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule